// File: doc/BRIEF.md
# MDIO Management Slave for an Eight-Port PHY

This block is the management-bus slave of an eight-port Ethernet PHY. It runs on a fast system clock and brings the MDC clock and MDIO data line in through synchronizers. On each rising MDC edge it takes one bit and walks through the clause-22 frame: preamble, start code, opcode, PHY address, register address, turnaround and sixteen data bits. A frame belongs to this slave when the two upper PHY address bits equal the strap inputs. The three lower bits then pick one of the eight ports.

Reads present a port and a register address to an external register array. The array answers one clock later. The block then drives the turnaround zero and the data onto the MDIO line through a separate enable. Writes deliver a single strobe carrying the port, the register and the data word.

Once one frame has been accepted, later frames may omit the preamble, provided at least one idle bit comes before them.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset the output enable `mdio_oe` is low and the write strobe `reg_wr_en` is low.
- R2: On an addressed read (opcode bits 1 then 0), the slave leaves the line released during the first turnaround bit and drives 0 in the second. It then drives the 16 bits of the register at (PHY address bits [2:0], register address), most significant bit first, starting in the MDC cycle after the second turnaround bit. The slave never drives while the master drives.
- R3: On an addressed write (opcode bits 0 then 1), exactly one `reg_wr_en` pulse follows the 16th data bit. It carries the port (PHY address bits [2:0]), the register address and the data, taken most significant bit first.
- R4: A frame is addressed only when PHY address bits [4:3] equal `strap_base`. For any other frame the slave never asserts `mdio_oe` and never pulses `reg_wr_en`.
- R5: Until the first addressed frame completes after reset, a start code is recognised only after at least 32 consecutive ones. A frame preceded by 31 ones is ignored.
- R6: After an addressed frame has completed, a frame with no preamble is accepted when at least one idle bit (a one) comes before its start code.
- R7: A frame whose start code is not 0 then 1, or whose opcode is 00 or 11, is discarded without driving the line or writing. The slave then hunts for a new start condition.
- R8: A frame with a non-matching address is still tracked to its full length, so a preamble-less frame right after it is decoded correctly.
- R9: The slave releases `mdio_oe` after the 16th read data bit, so the line is undriven during the idle bit that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_base | input | 2 | Strapped value for PHY address bits [4:3] |
| mdc | input | 1 | Management clock from the master |
| mdio_in | input | 1 | Resolved level of the MDIO line |
| mdio_out | output | 1 | Value the slave drives onto MDIO |
| mdio_oe | output | 1 | Drive enable for the MDIO tri-state buffer |
| reg_rd_port | output | 3 | Port index for the register read |
| reg_rd_addr | output | 5 | Register address for the read |
| reg_rd_data | input | 16 | Read data, valid one clock after the address |
| reg_wr_en | output | 1 | One-clock write strobe |
| reg_wr_port | output | 3 | Port index for the write |
| reg_wr_addr | output | 5 | Register address for the write |
| reg_wr_data | output | 16 | Write data |

## Verification
The assertions assume that MDC is slow compared with the system clock, so each MDC phase lasts several clock cycles after synchronization. They also assume that the master changes MDIO only while MDC is low and releases the line during read turnaround and read data. The bench produces MDC as a 20-clock period and changes master data only at the falling MDC edge. It releases the line for every bit that the slave may own, and it flags any cycle in which both sides drive. Frames that break the format are followed by a long run of idle ones, which returns a correct slave to a known hunting state.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    S_HUNT,
    S_ST1,
    S_OP,
    S_ADR,
    S_TA,
    S_DAT
  } mdio_st_e;

  // A start code may begin after a full run of ones, or after a single
  // idle one once the slave has been primed by an accepted frame.
  function automatic logic start_allowed(input int ones, input int need,
                                         input logic primed);
    return (ones >= need) || (primed && ones > 0);
  endfunction

  function automatic logic op_legal(input logic [1:0] op);
    return (op == 2'b10) || (op == 2'b01);
  endfunction

  function automatic logic op_is_read(input logic [1:0] op);
    return op == 2'b10;
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio,
  output logic rise,
  output logic bit_val
);
  logic [STAGES-1:0] mdc_sh;
  logic [STAGES-1:0] dat_sh;
  logic              mdc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sh   <= '0;
      dat_sh   <= '1;
      mdc_prev <= 1'b0;
    end else begin
      mdc_sh   <= {mdc_sh[STAGES-2:0], mdc};
      dat_sh   <= {dat_sh[STAGES-2:0], mdio};
      mdc_prev <= mdc_sh[STAGES-1];
    end
  end

  assign rise    = mdc_sh[STAGES-1] & ~mdc_prev;
  assign bit_val = dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_parser.sv
module mdio_frame_parser
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int PORT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rise,
  input  logic                    bit_in,
  input  logic [PHY_W-PORT_W-1:0] strap_base,
  output logic                    ev_ta_first,
  output logic                    ev_ta_second,
  output logic                    ev_dat,
  output logic                    ev_last,
  output logic                    rd_frame,
  output logic [PORT_W-1:0]       port_q,
  output logic [REG_W-1:0]        reg_q,
  output logic                    wr_en,
  output logic [DATA_W-1:0]       wr_data
);
  localparam int AW     = PHY_W + REG_W;
  localparam int BASE_W = PHY_W - PORT_W;
  localparam int CNT_W  = $clog2(AW + DATA_W);
  localparam int ONES_W = $clog2(PRE_LEN + 1);

  mdio_st_e            st;
  logic [CNT_W-1:0]    cnt;
  logic [ONES_W-1:0]   ones;
  logic [1:0]          op_q;
  logic [AW-1:0]       adr_sh;
  logic [DATA_W-1:0]   dat_sh;
  logic                hit_q, rd_q, primed;
  logic [AW-1:0]       adr_next;
  logic                ev_adr_done;

  assign adr_next     = {adr_sh[AW-2:0], bit_in};
  assign ev_adr_done  = rise && st == S_ADR && cnt == CNT_W'(AW - 1);
  assign ev_ta_first  = rise && st == S_TA && cnt == '0;
  assign ev_ta_second = rise && st == S_TA && cnt == CNT_W'(1);
  assign ev_dat       = rise && st == S_DAT;
  assign ev_last      = ev_dat && cnt == CNT_W'(DATA_W - 1);
  assign rd_frame     = hit_q && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HUNT;
      cnt     <= '0;
      ones    <= '0;
      op_q    <= '0;
      adr_sh  <= '0;
      dat_sh  <= '0;
      hit_q   <= 1'b0;
      rd_q    <= 1'b0;
      primed  <= 1'b0;
      port_q  <= '0;
      reg_q   <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        case (st)
          S_HUNT: begin
            if (bit_in) begin
              if (ones != ONES_W'(PRE_LEN)) ones <= ones + 1'b1;
            end else if (start_allowed(int'(ones), PRE_LEN, primed)) begin
              st <= S_ST1;
            end else begin
              ones <= '0;
            end
          end
          S_ST1: begin
            cnt  <= '0;
            ones <= '0;
            st   <= bit_in ? S_OP : S_HUNT;
          end
          S_OP: begin
            op_q <= {op_q[0], bit_in};
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_W'(1)) begin
              cnt  <= '0;
              rd_q <= op_is_read({op_q[0], bit_in});
              st   <= op_legal({op_q[0], bit_in}) ? S_ADR : S_HUNT;
            end
          end
          S_ADR: begin
            adr_sh <= adr_next;
            cnt    <= cnt + 1'b1;
            if (ev_adr_done) begin
              cnt    <= '0;
              hit_q  <= adr_next[AW-1 -: BASE_W] == strap_base;
              port_q <= adr_next[REG_W +: PORT_W];
              reg_q  <= adr_next[REG_W-1:0];
              st     <= S_TA;
            end
          end
          S_TA: begin
            cnt <= cnt + 1'b1;
            if (ev_ta_second) begin
              cnt <= '0;
              st  <= S_DAT;
            end
          end
          S_DAT: begin
            dat_sh <= {dat_sh[DATA_W-2:0], bit_in};
            cnt    <= cnt + 1'b1;
            if (ev_last) begin
              wr_en   <= hit_q && !rd_q;
              wr_data <= {dat_sh[DATA_W-2:0], bit_in};
              primed  <= primed | hit_q;
              cnt     <= '0;
              ones    <= '0;
              st      <= S_HUNT;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  a_r5_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= ONES_W'(PRE_LEN));
  a_r6_primed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  a_r4_wr_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> hit_q && !rd_q);
endmodule

// File: rtl/mdio_read_driver.sv
module mdio_read_driver #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ta_first,
  input  logic              ev_ta_second,
  input  logic              ev_dat,
  input  logic              ev_last,
  input  logic              rd_frame,
  input  logic [DATA_W-1:0] rd_data,
  output logic              oe,
  output logic              out
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe  <= 1'b0;
      out <= 1'b0;
      sh  <= '0;
    end else if (ev_ta_first && rd_frame) begin
      oe  <= 1'b1;
      out <= 1'b0;
    end else if (ev_ta_second && oe) begin
      out <= rd_data[DATA_W-1];
      sh  <= {rd_data[DATA_W-2:0], 1'b0};
    end else if (ev_dat && oe) begin
      if (ev_last) begin
        oe  <= 1'b0;
        out <= 1'b0;
      end else begin
        out <= sh[DATA_W-1];
        sh  <= {sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  a_r2_ta_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !out);
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> !oe);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int PRE_LEN     = 32,
  parameter int DATA_W      = 16,
  parameter int PHY_W       = 5,
  parameter int REG_W       = 5,
  parameter int PORT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PHY_W-PORT_W-1:0] strap_base,
  input  logic                    mdc,
  input  logic                    mdio_in,
  output logic                    mdio_out,
  output logic                    mdio_oe,
  output logic [PORT_W-1:0]       reg_rd_port,
  output logic [REG_W-1:0]        reg_rd_addr,
  input  logic [DATA_W-1:0]       reg_rd_data,
  output logic                    reg_wr_en,
  output logic [PORT_W-1:0]       reg_wr_port,
  output logic [REG_W-1:0]        reg_wr_addr,
  output logic [DATA_W-1:0]       reg_wr_data
);
  logic rise, bit_val;
  logic ev_ta_first, ev_ta_second, ev_dat, ev_last, rd_frame;
  logic [PORT_W-1:0] port_q;
  logic [REG_W-1:0]  reg_q;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio(mdio_in),
    .rise(rise), .bit_val(bit_val)
  );

  mdio_frame_parser #(
    .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .PHY_W(PHY_W),
    .REG_W(REG_W), .PORT_W(PORT_W)
  ) u_parse (
    .clk(clk), .rst_n(rst_n), .rise(rise), .bit_in(bit_val),
    .strap_base(strap_base),
    .ev_ta_first(ev_ta_first), .ev_ta_second(ev_ta_second),
    .ev_dat(ev_dat), .ev_last(ev_last), .rd_frame(rd_frame),
    .port_q(port_q), .reg_q(reg_q),
    .wr_en(reg_wr_en), .wr_data(reg_wr_data)
  );

  mdio_read_driver #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .ev_ta_first(ev_ta_first), .ev_ta_second(ev_ta_second),
    .ev_dat(ev_dat), .ev_last(ev_last), .rd_frame(rd_frame),
    .rd_data(reg_rd_data), .oe(mdio_oe), .out(mdio_out)
  );

  assign reg_rd_port = port_q;
  assign reg_rd_addr = reg_q;
  assign reg_wr_port = port_q;
  assign reg_wr_addr = reg_q;

  a_r4_drive_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> rd_frame);
  a_r7_no_drive_and_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(mdio_oe && reg_wr_en));
endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
  localparam int HALF = 10;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic drv_en = 1'b0, drv_val = 1'b1;
  logic mdio_line, mdio_out, mdio_oe;
  logic [2:0] reg_rd_port, reg_wr_port;
  logic [4:0] reg_rd_addr, reg_wr_addr;
  logic [15:0] reg_rd_data, reg_wr_data;
  logic reg_wr_en;

  logic [15:0] rf [8][32];
  logic [15:0] exp_rf [8][32];
  int wr_cnt = 0, contention = 0;
  logic [2:0] last_port;
  logic [4:0] last_addr;
  logic [15:0] last_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_out : (drv_en ? drv_val : 1'b1);

  mdio_mgmt_slave u_dut (
    .clk(clk), .rst_n(rst_n), .strap_base(STRAP), .mdc(mdc),
    .mdio_in(mdio_line), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .reg_rd_port(reg_rd_port), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en),
    .reg_wr_port(reg_wr_port), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data)
  );

  function automatic logic [15:0] init_val(input int p, input int a);
    return {p[2:0], a[4:0], 8'hC3} ^ 16'h5a00;
  endfunction

  initial begin
    for (int p = 0; p < 8; p++)
      for (int a = 0; a < 32; a++) begin
        rf[p][a]     = init_val(p, a);
        exp_rf[p][a] = init_val(p, a);
      end
  end

  always @(posedge clk) begin
    reg_rd_data <= rf[reg_rd_port][reg_rd_addr];
    if (reg_wr_en) begin
      rf[reg_wr_port][reg_wr_addr] <= reg_wr_data;
      wr_cnt    <= wr_cnt + 1;
      last_port <= reg_wr_port;
      last_addr <= reg_wr_addr;
      last_data <= reg_wr_data;
    end
  end

  always @(negedge clk) if (drv_en && mdio_oe) contention++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic m_en, input logic m_val,
                           output logic smp, output logic smp_oe);
    drv_en  = m_en;
    drv_val = m_val;
    repeat (HALF) @(negedge clk);
    smp    = mdio_line;
    smp_oe = mdio_oe;
    mdc    = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc    = 1'b0;
  endtask

  task automatic send_frame(input int pre, input logic [1:0] stc,
                            input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [15:0] wd,
                            output logic [15:0] rd, output logic ta_ok,
                            output logic drove, output logic idle_oe);
    logic s, o;
    drove = 0; rd = '0; ta_ok = 0; idle_oe = 0;
    for (int i = 0; i < pre; i++) begin bit_cycle(1, 1, s, o); drove |= o; end
    for (int i = 1; i >= 0; i--) begin bit_cycle(1, stc[i], s, o); drove |= o; end
    for (int i = 1; i >= 0; i--) begin bit_cycle(1, op[i], s, o); drove |= o; end
    if (stc != 2'b01 || op == 2'b00 || op == 2'b11) begin
      for (int i = 0; i < 40; i++) begin bit_cycle(0, 0, s, o); drove |= o; end
      return;
    end
    for (int i = 4; i >= 0; i--) begin bit_cycle(1, phy[i], s, o); drove |= o; end
    for (int i = 4; i >= 0; i--) begin bit_cycle(1, ra[i], s, o); drove |= o; end
    if (op == 2'b10) begin
      bit_cycle(0, 0, s, o); drove |= o; ta_ok = !o && s;
      bit_cycle(0, 0, s, o); drove |= o; ta_ok &= o && !s;
      for (int i = 15; i >= 0; i--) begin bit_cycle(0, 0, s, o); drove |= o; rd[i] = s; end
    end else begin
      bit_cycle(1, 1, s, o); drove |= o;
      bit_cycle(1, 0, s, o); drove |= o;
      for (int i = 15; i >= 0; i--) begin bit_cycle(1, wd[i], s, o); drove |= o; end
    end
    bit_cycle(0, 0, s, o);
    idle_oe = o;
  endtask

  task automatic do_write(input int pre, input logic [2:0] port,
                          input logic [4:0] ra, input logic [15:0] d,
                          input bit match);
    logic [15:0] rd; logic ta, dr, io; int w0;
    w0 = wr_cnt;
    send_frame(pre, 2'b01, 2'b01, {match ? STRAP : ~STRAP, port}, ra, d,
               rd, ta, dr, io);
    chk(!dr, "R4 no drive on write", dr, 0);
    if (match) begin
      chk(wr_cnt == w0 + 1, "R3 strobe count", wr_cnt - w0, 1);
      chk(last_data == d && last_port == port && last_addr == ra,
          "R3 strobe fields", {last_port, last_addr, last_data}, {port, ra, d});
      exp_rf[port][ra] = d;
    end else begin
      chk(wr_cnt == w0, "R4 mismatched write", wr_cnt - w0, 0);
    end
  endtask

  task automatic do_read(input int pre, input logic [2:0] port,
                         input logic [4:0] ra, input bit match);
    logic [15:0] rd; logic ta, dr, io;
    send_frame(pre, 2'b01, 2'b10, {match ? STRAP : ~STRAP, port}, ra, 16'h0,
               rd, ta, dr, io);
    if (match) begin
      chk(rd == exp_rf[port][ra], "R2 read data", rd, exp_rf[port][ra]);
      chk(ta, "R2 turnaround", ta, 1);
      chk(!io, "R9 release after data", io, 0);
    end else begin
      chk(!dr, "R4 mismatched read drove", dr, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd; logic ta, dr, io, s, o; int w0;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    chk(!mdio_oe && !reg_wr_en, "R1 reset state", {mdio_oe, reg_wr_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mdio_oe && !reg_wr_en, "R1 after release", {mdio_oe, reg_wr_en}, 0);

    // R5: 31 ones is short of the first-frame preamble
    send_frame(31, 2'b01, 2'b10, {STRAP, 3'd0}, 5'd1, 16'h0, rd, ta, dr, io);
    chk(!dr, "R5 short-preamble read drove", dr, 0);
    bit_cycle(1, 0, s, o);
    w0 = wr_cnt;
    send_frame(31, 2'b01, 2'b01, {STRAP, 3'd0}, 5'd1, 16'hDEAD, rd, ta, dr, io);
    chk(wr_cnt == w0, "R5 short-preamble write", wr_cnt - w0, 0);
    bit_cycle(1, 0, s, o);

    // first valid frame with a full preamble, then suppressed frames (R6)
    do_write(32, 3'd0, 5'd1, 16'h1234, 1);
    do_read(0, 3'd0, 5'd1, 1);
    do_write(0, 3'd7, 5'd31, 16'hFFFF, 1);
    do_read(0, 3'd7, 5'd31, 1);
    do_write(0, 3'd3, 5'd0, 16'h0000, 1);
    do_read(0, 3'd3, 5'd0, 1);
    do_write(0, 3'd5, 5'd9, 16'h8001, 1);
    do_read(0, 3'd5, 5'd9, 1);

    // R8: mismatched frames keep the slave in step
    do_write(0, 3'd5, 5'd9, 16'h7E7E, 0);
    do_read(0, 3'd5, 5'd9, 1);
    do_read(0, 3'd2, 5'd4, 0);
    do_read(0, 3'd2, 5'd4, 1);

    // R7: bad start code and illegal opcodes
    w0 = wr_cnt;
    send_frame(32, 2'b00, 2'b01, {STRAP, 3'd1}, 5'd2, 16'h0, rd, ta, dr, io);
    chk(!dr, "R7 bad start drove", dr, 0);
    send_frame(0, 2'b01, 2'b11, {STRAP, 3'd1}, 5'd2, 16'h0, rd, ta, dr, io);
    chk(!dr, "R7 opcode 11 drove", dr, 0);
    send_frame(0, 2'b01, 2'b00, {STRAP, 3'd1}, 5'd2, 16'h0, rd, ta, dr, io);
    chk(!dr, "R7 opcode 00 drove", dr, 0);
    chk(wr_cnt == w0, "R7 no write", wr_cnt - w0, 0);
    do_read(0, 3'd1, 5'd2, 1);

    // all ports (R4 lower address bits)
    for (int p = 0; p < 8; p++) do_write(0, p[2:0], 5'd17, 16'hA000 | 16'(p), 1);
    for (int p = 7; p >= 0; p--) do_read(0, p[2:0], 5'd17, 1);

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      logic [2:0] p; logic [4:0] a; logic [15:0] d; bit m; int pr;
      p  = 3'($urandom % 8);
      a  = 5'($urandom % 32);
      d  = 16'($urandom);
      m  = ($urandom % 5) != 0;
      pr = ($urandom % 2) ? 32 : 0;
      if ($urandom % 2) do_write(pr, p, a, d, m);
      else              do_read(pr, p, a, m);
    end

    chk(contention == 0, "R2 bus contention", contention, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule